// File: doc/BRIEF.md
# CAN Fault Status and Capture Unit

This block collects fault events from a CAN protocol engine into a byte of sticky status flags. Each flag has its own enable bit, and together they drive one level-sensitive interrupt request. Two capture registers record the details of the latest fault of their kind. The error-code register stores a two-bit error code and a five-bit state field for a bus error. The arbitration register stores the identifier bit position at which arbitration was lost. Once a capture register has loaded a value, it ignores new events until software reads it. That read also clears the matching flag.

The unit also holds the transmit and receive error counters and an error-warning limit. The protocol engine applies its fault-confinement results through load requests. Software may write the counters only while the controller is held in reset mode. A bus-off event forces the counters to fixed values. Software reaches everything through a small register port with a 3-bit address and separate read and write strobes. Read data is combinational from the address. A read strobe on a capture register causes its side effects at the next clock edge.

Top module: `can_fault_status`

## Requirements
- R1: After reset the values are: status 00h, enable 00h, both error counters 00h, warning limit 96h, both capture registers 00h, and the interrupt low. The address map is: 0 status, 1 enable, 2 transmit counter, 3 receive counter, 4 warning limit, 5 error-code capture, 6 arbitration capture.
- R2: A pulse on `fault_ev[i]` sets status bit i, and the bit stays set until its own clearing action. The bit order is: 0 bus-off, 1 error-passive, 2 error-warning, 3 pre-buffer overflow, 4 arbitration-lost, 5 bus-error. Status bits 7:6 read 0.
- R3: Writing 1 to status bits 0 to 3 clears those flags. Writing 0 has no effect. Writes to bits 4 and 5 have no effect. An event in the same cycle as a clearing write leaves its flag set.
- R4: The arbitration-lost flag clears only on a read of address 6. The bus-error flag clears only on a read of address 5.
- R5: The arbitration capture reads `arb_bit` in bits 4:0. It loads on an arbitration-lost event only while unlocked, locks on load, and unlocks on a read of address 6.
- R6: The error-code capture reads `err_code` in bits 7:6 and `err_state` in bits 4:0, with bit 5 reading 0. It follows the same lock rule as R5, with address 5 as its read.
- R7: A capture event in the same cycle as a read of its register returns the old value on that read. The new value is loaded, the register stays locked, and the flag stays set.
- R8: `irq` is high exactly when some status bit and its enable bit (enable register bit of the same position) are both 1.
- R9: Software writes to addresses 2 and 3 take effect only while `cfg_reset_mode` is 1. An engine load request (`ld_tx` or `ld_rx`) loads its value in any mode and takes priority over a software write.
- R10: A bus-off event sets the transmit counter to 128 and the receive counter to 0. This takes priority over load requests and writes in the same cycle.
- R11: The warning limit and the enable register take software writes at any time and read back the value written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 3 | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe (side effects on capture registers) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| fault_ev | input | 6 | Fault event pulses, bit order as in R2 |
| arb_bit | input | 5 | Identifier bit position of an arbitration loss |
| err_code | input | 2 | Bus-error code |
| err_state | input | 5 | Bus-error frame state |
| ld_tx | input | 1 | Engine load request, transmit counter |
| ld_tx_val | input | 8 | Transmit counter load value |
| ld_rx | input | 1 | Engine load request, receive counter |
| ld_rx_val | input | 8 | Receive counter load value |
| cfg_reset_mode | input | 1 | Controller held in reset mode |
| irq | output | 1 | Frame-error interrupt request |

## Verification
The bench sweeps every combination of flag pattern and enable mask. A wrong mask or OR tree would raise the interrupt for disabled flags or miss enabled ones. Each capture register is swept over all of its values. A second event fires while the register is locked, so a missing lock shows up as an overwritten value. Reads and events are also issued in the same cycle: a design that let the read win would drop the new capture or clear the flag. Clearing writes are aimed at the read-cleared bits, counter writes are made outside reset mode, and a bus-off event arrives together with a load request, to catch a wrong clear path and a wrong priority order.

// File: rtl/cfs_pkg.sv
package cfs_pkg;
  localparam int ADDR_W = 3;
  localparam int NFLAG  = 6;

  localparam logic [ADDR_W-1:0] A_STAT = 3'd0;
  localparam logic [ADDR_W-1:0] A_EN   = 3'd1;
  localparam logic [ADDR_W-1:0] A_TXC  = 3'd2;
  localparam logic [ADDR_W-1:0] A_RXC  = 3'd3;
  localparam logic [ADDR_W-1:0] A_WARN = 3'd4;
  localparam logic [ADDR_W-1:0] A_CODE = 3'd5;
  localparam logic [ADDR_W-1:0] A_ARB  = 3'd6;

  localparam int F_BOFF = 0;
  localparam int F_PASS = 1;
  localparam int F_WARN = 2;
  localparam int F_OVF  = 3;
  localparam int F_ARB  = 4;
  localparam int F_BERR = 5;

  // flags that clear by writing one
  localparam logic [NFLAG-1:0] W1C_MASK = 6'b001111;
endpackage

// File: rtl/cfs_rst_sync.sv
module cfs_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sh_q[STAGES-1];
endmodule

// File: rtl/cfs_flag_bank.sv
module cfs_flag_bank #(
  parameter int N = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  input  logic         en_wr_i,
  input  logic [N-1:0] en_wdata_i,
  output logic [N-1:0] flags_o,
  output logic [N-1:0] en_o,
  output logic         irq_o
);
  logic [N-1:0] flag_q, flag_d;
  logic [N-1:0] en_q, en_d;

  for (genvar i = 0; i < N; i++) begin : g_flag
    // a new event outranks any clear in the same cycle
    always_comb flag_d[i] = set_i[i] | (flag_q[i] & ~clr_i[i]);
  end

  always_comb en_d = en_wr_i ? en_wdata_i : en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
      en_q   <= '0;
    end else begin
      flag_q <= flag_d;
      en_q   <= en_d;
    end
  end

  assign flags_o = flag_q;
  assign en_o    = en_q;
  assign irq_o   = |(flag_q & en_q);
endmodule

// File: rtl/cfs_capture.sv
module cfs_capture #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cap_i,
  input  logic [W-1:0] val_i,
  input  logic         rd_i,
  output logic [W-1:0] val_o,
  output logic         locked_o
);
  logic [W-1:0] val_q, val_d;
  logic         lock_q, lock_d;
  logic         take;

  always_comb begin
    take   = cap_i & (~lock_q | rd_i);
    val_d  = take ? val_i : val_q;
    lock_d = cap_i ? 1'b1 : (rd_i ? 1'b0 : lock_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q  <= '0;
      lock_q <= 1'b0;
    end else begin
      val_q  <= val_d;
      lock_q <= lock_d;
    end
  end

  assign val_o    = val_q;
  assign locked_o = lock_q;
endmodule

// File: rtl/cfs_err_counters.sv
module cfs_err_counters #(
  parameter int          W        = 8,
  parameter int          BOFF_TX  = 128,
  parameter logic [7:0]  WARN_RST = 8'h96
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bus_off_i,
  input  logic         reset_mode_i,
  input  logic         ld_tx_i,
  input  logic [W-1:0] ld_tx_val_i,
  input  logic         ld_rx_i,
  input  logic [W-1:0] ld_rx_val_i,
  input  logic         wr_tx_i,
  input  logic         wr_rx_i,
  input  logic         wr_warn_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] tx_o,
  output logic [W-1:0] rx_o,
  output logic [W-1:0] warn_o
);
  localparam logic [W-1:0] TX_BOFF = W'(BOFF_TX);

  logic [W-1:0] tx_q, tx_d, rx_q, rx_d, warn_q, warn_d;

  always_comb begin
    tx_d   = tx_q;
    rx_d   = rx_q;
    warn_d = wr_warn_i ? wdata_i : warn_q;
    if (bus_off_i) begin
      tx_d = TX_BOFF;
      rx_d = '0;
    end else begin
      if (ld_tx_i)                      tx_d = ld_tx_val_i;
      else if (wr_tx_i && reset_mode_i) tx_d = wdata_i;
      if (ld_rx_i)                      rx_d = ld_rx_val_i;
      else if (wr_rx_i && reset_mode_i) rx_d = wdata_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q   <= '0;
      rx_q   <= '0;
      warn_q <= W'(WARN_RST);
    end else begin
      tx_q   <= tx_d;
      rx_q   <= rx_d;
      warn_q <= warn_d;
    end
  end

  assign tx_o   = tx_q;
  assign rx_o   = rx_q;
  assign warn_o = warn_q;
endmodule

// File: rtl/can_fault_status.sv
module can_fault_status
  import cfs_pkg::*;
#(
  parameter int         DATA_W   = 8,
  parameter int         ARB_W    = 5,
  parameter int         CODE_W   = 2,
  parameter int         STATE_W  = 5,
  parameter int         BOFF_TX  = 128,
  parameter logic [7:0] WARN_RST = 8'h96
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic               reg_wr,
  input  logic               reg_rd,
  input  logic [DATA_W-1:0]  reg_wdata,
  output logic [DATA_W-1:0]  reg_rdata,
  input  logic [NFLAG-1:0]   fault_ev,
  input  logic [ARB_W-1:0]   arb_bit,
  input  logic [CODE_W-1:0]  err_code,
  input  logic [STATE_W-1:0] err_state,
  input  logic               ld_tx,
  input  logic [DATA_W-1:0]  ld_tx_val,
  input  logic               ld_rx,
  input  logic [DATA_W-1:0]  ld_rx_val,
  input  logic               cfg_reset_mode,
  output logic               irq
);
  localparam int ECC_W   = CODE_W + STATE_W;
  localparam int ECC_PAD = DATA_W - ECC_W;
  localparam int ARB_PAD = DATA_W - ARB_W;

  logic                rst_n_s;
  logic [NFLAG-1:0]    flag_q, en_q, flag_clr;
  logic                rd_arb, rd_code, wr_stat;
  logic [ARB_W-1:0]    arb_val;
  logic [ECC_W-1:0]    ecc_val;
  logic                arb_locked, ecc_locked;
  logic [DATA_W-1:0]   tx_cnt, rx_cnt, warn_lim;

  cfs_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_s)
  );

  always_comb begin
    wr_stat = reg_wr && (reg_addr == A_STAT);
    rd_arb  = reg_rd && (reg_addr == A_ARB);
    rd_code = reg_rd && (reg_addr == A_CODE);
    flag_clr         = {NFLAG{wr_stat}} & reg_wdata[NFLAG-1:0] & W1C_MASK;
    flag_clr[F_ARB]  = rd_arb;
    flag_clr[F_BERR] = rd_code;
  end

  cfs_flag_bank #(.N(NFLAG)) u_flags (
    .clk(clk), .rst_n(rst_n_s),
    .set_i(fault_ev), .clr_i(flag_clr),
    .en_wr_i(reg_wr && (reg_addr == A_EN)),
    .en_wdata_i(reg_wdata[NFLAG-1:0]),
    .flags_o(flag_q), .en_o(en_q), .irq_o(irq)
  );

  cfs_capture #(.W(ARB_W)) u_arb_cap (
    .clk(clk), .rst_n(rst_n_s),
    .cap_i(fault_ev[F_ARB]), .val_i(arb_bit), .rd_i(rd_arb),
    .val_o(arb_val), .locked_o(arb_locked)
  );

  cfs_capture #(.W(ECC_W)) u_ecc_cap (
    .clk(clk), .rst_n(rst_n_s),
    .cap_i(fault_ev[F_BERR]), .val_i({err_code, err_state}), .rd_i(rd_code),
    .val_o(ecc_val), .locked_o(ecc_locked)
  );

  cfs_err_counters #(.W(DATA_W), .BOFF_TX(BOFF_TX), .WARN_RST(WARN_RST)) u_cnt (
    .clk(clk), .rst_n(rst_n_s),
    .bus_off_i(fault_ev[F_BOFF]), .reset_mode_i(cfg_reset_mode),
    .ld_tx_i(ld_tx), .ld_tx_val_i(ld_tx_val),
    .ld_rx_i(ld_rx), .ld_rx_val_i(ld_rx_val),
    .wr_tx_i(reg_wr && (reg_addr == A_TXC)),
    .wr_rx_i(reg_wr && (reg_addr == A_RXC)),
    .wr_warn_i(reg_wr && (reg_addr == A_WARN)),
    .wdata_i(reg_wdata),
    .tx_o(tx_cnt), .rx_o(rx_cnt), .warn_o(warn_lim)
  );

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      A_STAT: reg_rdata[NFLAG-1:0] = flag_q;
      A_EN:   reg_rdata[NFLAG-1:0] = en_q;
      A_TXC:  reg_rdata = tx_cnt;
      A_RXC:  reg_rdata = rx_cnt;
      A_WARN: reg_rdata = warn_lim;
      A_CODE: reg_rdata = {ecc_val[ECC_W-1:STATE_W], {ECC_PAD{1'b0}}, ecc_val[STATE_W-1:0]};
      A_ARB:  reg_rdata = {{ARB_PAD{1'b0}}, arb_val};
      default: reg_rdata = '0;
    endcase
  end

  // error-code lock state is observed only through the read path
  logic ecc_lock_unused;
  assign ecc_lock_unused = ecc_locked;
endmodule

// File: rtl/can_fault_status_chk.sv
module can_fault_status_chk
  import cfs_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int ARB_W   = 5,
  parameter int BOFF_TX = 128
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              reg_wr,
  input logic              reg_rd,
  input logic [NFLAG-1:0]  wdat,
  input logic [NFLAG-1:0]  fault_ev,
  input logic              ld_tx,
  input logic              cfg_reset_mode,
  input logic              irq,
  input logic [NFLAG-1:0]  flags,
  input logic [DATA_W-1:0] tx_cnt,
  input logic [DATA_W-1:0] rx_cnt,
  input logic [ARB_W-1:0]  arb_val,
  input logic              arb_locked
);
  p_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fault_ev[F_OVF] |=> flags[F_OVF]);

  p_w1c_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == A_STAT && wdat[F_BOFF] && !fault_ev[F_BOFF]) |=> !flags[F_BOFF]);

  p_read_only_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (flags[F_BERR] && !(reg_rd && reg_addr == A_CODE)) |=> flags[F_BERR]);

  p_lock_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (arb_locked && !(reg_rd && reg_addr == A_ARB)) |=> $stable(arb_val));

  p_capture_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_ev[F_ARB] && reg_rd && reg_addr == A_ARB) |=> (flags[F_ARB] && arb_locked));

  p_mask_all_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == A_EN && wdat == '0) |=> !irq);

  p_write_guard_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == A_TXC && !cfg_reset_mode && !fault_ev[F_BOFF] && !ld_tx)
      |=> $stable(tx_cnt));

  p_bus_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fault_ev[F_BOFF] |=> (tx_cnt == DATA_W'(BOFF_TX) && rx_cnt == '0));
endmodule

bind can_fault_status can_fault_status_chk #(
  .DATA_W(DATA_W), .ARB_W(ARB_W), .BOFF_TX(BOFF_TX)
) chk_i (
  .clk(clk), .rst_n(rst_n_s), .reg_addr(reg_addr), .reg_wr(reg_wr),
  .reg_rd(reg_rd), .wdat(reg_wdata[cfs_pkg::NFLAG-1:0]), .fault_ev(fault_ev),
  .ld_tx(ld_tx), .cfg_reset_mode(cfg_reset_mode), .irq(irq),
  .flags(flag_q), .tx_cnt(tx_cnt), .rx_cnt(rx_cnt),
  .arb_val(arb_val), .arb_locked(arb_locked)
);

// File: tb/can_fault_status_tb.sv
module can_fault_status_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] reg_addr;
  logic       reg_wr, reg_rd;
  logic [7:0] reg_wdata;
  logic [7:0] reg_rdata;
  logic [5:0] fault_ev;
  logic [4:0] arb_bit;
  logic [1:0] err_code;
  logic [4:0] err_state;
  logic       ld_tx, ld_rx;
  logic [7:0] ld_tx_val, ld_rx_val;
  logic       cfg_reset_mode;
  logic       irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  can_fault_status dut_i (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .fault_ev(fault_ev), .arb_bit(arb_bit), .err_code(err_code),
    .err_state(err_state), .ld_tx(ld_tx), .ld_tx_val(ld_tx_val),
    .ld_rx(ld_rx), .ld_rx_val(ld_rx_val), .cfg_reset_mode(cfg_reset_mode),
    .irq(irq)
  );

  task automatic chk(string tag, int got, int exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic idle();
    reg_wr = 0; reg_rd = 0; fault_ev = '0; ld_tx = 0; ld_rx = 0;
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk); idle();
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1; tick();
  endtask

  task automatic peek(logic [2:0] a, output logic [7:0] d);
    reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic rd(logic [2:0] a, output logic [7:0] d);
    reg_addr = a; reg_rd = 1; #1 d = reg_rdata; tick();
  endtask

  task automatic fire(logic [5:0] ev, logic [4:0] ab, logic [1:0] c, logic [4:0] s);
    fault_ev = ev; arb_bit = ab; err_code = c; err_state = s; tick();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] d, d2;
    idle();
    reg_addr = 0; reg_wdata = 0; arb_bit = 0; err_code = 0; err_state = 0;
    ld_tx_val = 0; ld_rx_val = 0; cfg_reset_mode = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1 reset values
    peek(3'd0, d); chk("R1 status", d, 8'h00);
    peek(3'd1, d); chk("R1 enable", d, 8'h00);
    peek(3'd2, d); chk("R1 tx", d, 8'h00);
    peek(3'd3, d); chk("R1 rx", d, 8'h00);
    peek(3'd4, d); chk("R1 warn", d, 8'h96);
    peek(3'd5, d); chk("R1 code cap", d, 8'h00);
    peek(3'd6, d); chk("R1 arb cap", d, 8'h00);
    chk("R1 irq", irq, 0);

    // R2 / R8 sweep of flag pattern and enable mask
    for (int p = 0; p < 64; p++) begin
      wr(3'd1, 8'h00);
      fire(p[5:0], 5'd0, 2'd0, 5'd0);
      peek(3'd0, d); chk("R2 status set", d, p);
      for (int e = 0; e < 64; e++) begin
        wr(3'd1, e[7:0]);
        chk("R8 irq", irq, ((p & e) != 0) ? 1 : 0);
      end
      wr(3'd0, 8'h0F); rd(3'd5, d); rd(3'd6, d);
      peek(3'd0, d); chk("R2 cleared", d, 0);
    end
    wr(3'd1, 8'h00);

    // R3 write-one-to-clear
    fire(6'h3F, 5'd0, 2'd0, 5'd0);
    wr(3'd0, 8'hF0); peek(3'd0, d); chk("R3 upper bits ignore", d, 8'h3F);
    wr(3'd0, 8'h00); peek(3'd0, d); chk("R3 zero ignore", d, 8'h3F);
    for (int i = 0; i < 4; i++) begin
      wr(3'd0, 8'(1 << i)); peek(3'd0, d);
      chk("R3 w1c", d, 8'h3F & ~((2 << i) - 1));
    end
    fault_ev = 6'h01; reg_addr = 3'd0; reg_wdata = 8'h01; reg_wr = 1; tick();
    peek(3'd0, d); chk("R3 event beats clear", d, 8'h31);
    wr(3'd0, 8'h01);
    // R4 read-clear of the capture flags
    peek(3'd6, d); peek(3'd0, d); chk("R4 peek no clear", d, 8'h30);
    rd(3'd6, d); peek(3'd0, d); chk("R4 arb read clears", d, 8'h20);
    rd(3'd5, d); peek(3'd0, d); chk("R4 code read clears", d, 8'h00);

    // R5 arbitration capture lock
    for (int b = 0; b < 32; b++) begin
      fire(6'h10, 5'(b), 2'd0, 5'd0);
      fire(6'h10, 5'(~b), 2'd0, 5'd0);
      rd(3'd6, d); chk("R5 locked value", d, b);
      peek(3'd0, d); chk("R5 flag cleared", d[4], 0);
      fire(6'h10, 5'(b + 7), 2'd0, 5'd0);
      rd(3'd6, d); chk("R5 rearmed", d, (b + 7) % 32);
    end

    // R6 error-code capture
    for (int c = 0; c < 4; c++)
      for (int s = 0; s < 32; s++) begin
        fire(6'h20, 5'd0, 2'(c), 5'(s));
        fire(6'h20, 5'd0, 2'(~c), 5'(~s));
        rd(3'd6 - 3'd1, d); chk("R6 code layout", d, (c << 6) | s);
      end

    // R7 same-cycle capture and read
    fire(6'h10, 5'd3, 2'd0, 5'd0);
    fault_ev = 6'h10; arb_bit = 5'd9; reg_addr = 3'd6; reg_rd = 1;
    #1 d = reg_rdata; tick();
    chk("R7 old value read", d, 3);
    peek(3'd0, d2); chk("R7 flag kept", d2[4], 1);
    fire(6'h10, 5'd20, 2'd0, 5'd0);
    rd(3'd6, d); chk("R7 new capture locked", d, 9);
    fire(6'h20, 5'd0, 2'd1, 5'd4);
    fault_ev = 6'h20; err_code = 2'd2; err_state = 5'd17; reg_addr = 3'd5; reg_rd = 1;
    #1 d = reg_rdata; tick();
    chk("R7 code old value", d, 8'h44);
    peek(3'd0, d2); chk("R7 code flag kept", d2[5], 1);
    rd(3'd5, d); chk("R7 code new capture", d, 8'h91);

    // R9 counter write guard and load requests
    cfg_reset_mode = 1;
    for (int v = 0; v < 256; v++) begin
      wr(3'd2, 8'(v)); wr(3'd3, 8'(255 - v));
      peek(3'd2, d); chk("R9 tx write", d, v);
      peek(3'd3, d); chk("R9 rx write", d, 255 - v);
    end
    wr(3'd2, 8'h11); wr(3'd3, 8'h22);
    cfg_reset_mode = 0;
    wr(3'd2, 8'h55); wr(3'd3, 8'h66);
    peek(3'd2, d); chk("R9 tx guarded", d, 8'h11);
    peek(3'd3, d); chk("R9 rx guarded", d, 8'h22);
    ld_tx = 1; ld_tx_val = 8'd77; ld_rx = 1; ld_rx_val = 8'd200; tick();
    peek(3'd2, d); chk("R9 tx load", d, 77);
    peek(3'd3, d); chk("R9 rx load", d, 200);
    cfg_reset_mode = 1;
    ld_tx = 1; ld_tx_val = 8'd5; reg_addr = 3'd2; reg_wdata = 8'd99; reg_wr = 1; tick();
    peek(3'd2, d); chk("R9 load beats write", d, 5);

    // R10 bus-off priority
    wr(3'd3, 8'd50);
    fault_ev = 6'h01; ld_tx = 1; ld_tx_val = 8'd3; ld_rx = 1; ld_rx_val = 8'd9; tick();
    peek(3'd2, d); chk("R10 tx preset", d, 128);
    peek(3'd3, d); chk("R10 rx cleared", d, 0);
    fault_ev = 6'h01; reg_addr = 3'd3; reg_wdata = 8'd44; reg_wr = 1; tick();
    peek(3'd3, d); chk("R10 over write", d, 0);
    cfg_reset_mode = 0;

    // R11 warning limit and enable read-back
    wr(3'd4, 8'h5A); peek(3'd4, d); chk("R11 warn", d, 8'h5A);
    wr(3'd1, 8'h2A); peek(3'd1, d); chk("R11 enable", d, 8'h2A);
    peek(3'd4, d); chk("R11 warn kept", d, 8'h5A);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule